// File: doc/BRIEF.md
# Halfword-Granule Instruction Fetch Unit

This unit fetches the instruction at a given program counter from a memory that returns one 16-bit halfword per access. The caller asserts a start strobe with the PC while the unit is idle. The unit first checks the PC alignment. It then translates and reads the halfword at the PC. When the two low bits of that halfword mark it as a compressed encoding, the unit stops there. Otherwise it translates and reads the halfword at PC+2 in a separate access, and joins the two halfwords into a 32-bit instruction.

Every access is translated and checked on its own. A fault therefore carries the exact halfword address that failed, either the PC or PC+2. The result comes out with a one-cycle valid strobe and a tag: a full 32-bit instruction, a 16-bit compressed instruction, or an exception with a cause and a faulting address. Both the translation port and the memory port use a valid/ready request followed by a single-cycle response, so each stage may stall for any number of cycles.

Top module: `ifu_fetch_top`

## Requirements
- R1: A start with pc_i bit 0 set returns res_tag_o=2 (exception), res_cause_o=0 (misaligned fetch) and res_addr_o=pc_i. The valid strobe comes on the cycle after the start, and no translation or memory request is issued.
- R2: A start with pc_i bit 1 set while rvc_en_i=0 returns the same misaligned exception (tag 2, cause 0, address pc_i) with no request issued. With rvc_en_i=1 the same PC is fetched normally.
- R3: A low halfword whose bits 1:0 are not 2'b11 gives res_tag_o=1. res_insn_o carries the halfword in bits 15:0 and zero in bits 31:16. Only one translation and one memory access are made.
- R4: A translation fault on the low access gives tag 2, res_cause_o set to the cause from the translation response, and res_addr_o=PC. No memory read is made.
- R5: A memory error on the low read gives tag 2, cause 1 (fetch access fault) and address PC.
- R6: When the low halfword has bits 1:0 = 2'b11, the unit translates and reads PC+2. A translation fault there reports the translation cause with address PC+2. A memory error there reports cause 1 with address PC+2.
- R7: A successful two-part fetch gives res_tag_o=0, with the high halfword in res_insn_o[31:16] and the low halfword in res_insn_o[15:0].
- R8: A translation or memory request holds its valid and its address stable until ready is seen. A response is taken whenever it arrives, one or more cycles after the request is accepted.
- R9: res_valid_o is a one-cycle pulse, and the result fields hold their values until the next result. ready_o is high only while the unit is idle, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a fetch (taken only when ready_o=1) |
| pc_i | input | XLEN | PC to fetch |
| rvc_en_i | input | 1 | Compressed encodings allowed (halfword-aligned PCs are legal) |
| ready_o | output | 1 | Unit idle, start accepted |
| tr_req_valid_o | output | 1 | Translation request valid |
| tr_req_ready_i | input | 1 | Translation request accepted |
| tr_vaddr_o | output | XLEN | Virtual address to translate |
| tr_rsp_valid_i | input | 1 | Translation response strobe |
| tr_rsp_fault_i | input | 1 | Translation failed |
| tr_rsp_cause_i | input | CAUSE_W | Cause code of a translation failure |
| tr_rsp_paddr_i | input | PA_W | Translated physical address |
| mem_req_valid_o | output | 1 | Halfword read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_addr_o | output | PA_W | Physical halfword address |
| mem_rsp_valid_i | input | 1 | Read response strobe |
| mem_rsp_err_i | input | 1 | Read failed |
| mem_rsp_data_i | input | 16 | Halfword read data |
| res_valid_o | output | 1 | Result strobe |
| res_tag_o | output | 2 | 0 full, 1 compressed, 2 exception |
| res_insn_o | output | 32 | Instruction bits |
| res_cause_o | output | CAUSE_W | Exception cause |
| res_addr_o | output | XLEN | Faulting address (exception) or PC |

## Verification
The hardest case to reach is a fault on the second access. The PC must be legal, the low halfword must carry 2'b11 in its low bits, and the low access must finish cleanly before the environment fails the request at PC+2. On top of that, the ready and response latencies vary at random on every handshake. The bench's translation and memory responders pick a fault point for each fetch and decide fail or pass by matching the request address against PC and PC+2. The random stimulus draws the low halfword's bottom bits so that full-length encodings come up often, and directed cases force a fault at each of the two addresses.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  typedef enum logic [1:0] {
    RES_FULL = 2'd0,
    RES_HALF = 2'd1,
    RES_EXC  = 2'd2
  } res_tag_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TREQ,
    S_TRSP,
    S_MREQ,
    S_MRSP
  } seq_state_e;

  localparam int unsigned CAUSE_MISALIGN = 0;
  localparam int unsigned CAUSE_ACCESS   = 1;
endpackage

// File: rtl/ifu_align_chk.sv
module ifu_align_chk #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            rvc_en_i,
  output logic            misalign_o
);
  assign misalign_o = pc_i[0] | (pc_i[1] & ~rvc_en_i);
endmodule

// File: rtl/ifu_half_classify.sv
module ifu_half_classify (
  input  logic [15:0] half_i,
  output logic        is_half_o
);
  assign is_half_o = (half_i[1:0] != 2'b11);
endmodule

// File: rtl/ifu_seq.sv
module ifu_seq
  import ifu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       tr_req_ready_i,
  input  logic       tr_rsp_valid_i,
  input  logic       tr_rsp_fault_i,
  input  logic       mem_req_ready_i,
  input  logic       mem_rsp_valid_i,
  input  logic       mem_rsp_err_i,
  input  logic       low_is_half_i,
  output seq_state_e state_o,
  output logic       hi_phase_o,
  output logic       advance_o,
  output logic       finish_o
);
  seq_state_e state_q, state_d;
  logic       hi_q;

  logic tr_done, mem_done;
  assign tr_done  = (state_q == S_TRSP) & tr_rsp_valid_i;
  assign mem_done = (state_q == S_MRSP) & mem_rsp_valid_i;

  assign advance_o = mem_done & ~mem_rsp_err_i & ~hi_q & ~low_is_half_i;
  assign finish_o  = (tr_done & tr_rsp_fault_i) | (mem_done & ~advance_o);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (go_i) state_d = S_TREQ;
      S_TREQ: if (tr_req_ready_i) state_d = S_TRSP;
      S_TRSP: if (tr_rsp_valid_i) state_d = tr_rsp_fault_i ? S_IDLE : S_MREQ;
      S_MREQ: if (mem_req_ready_i) state_d = S_MRSP;
      S_MRSP: if (mem_rsp_valid_i) state_d = advance_o ? S_TREQ : S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      hi_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (go_i && state_q == S_IDLE) hi_q <= 1'b0;
      else if (advance_o)            hi_q <= 1'b1;
    end
  end

  assign state_o    = state_q;
  assign hi_phase_o = hi_q;
endmodule

// File: rtl/ifu_fetch_top.sv
module ifu_fetch_top
  import ifu_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               rvc_en_i,
  output logic               ready_o,
  output logic               tr_req_valid_o,
  input  logic               tr_req_ready_i,
  output logic [XLEN-1:0]    tr_vaddr_o,
  input  logic               tr_rsp_valid_i,
  input  logic               tr_rsp_fault_i,
  input  logic [CAUSE_W-1:0] tr_rsp_cause_i,
  input  logic [PA_W-1:0]    tr_rsp_paddr_i,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic               mem_rsp_err_i,
  input  logic [15:0]        mem_rsp_data_i,
  output logic               res_valid_o,
  output logic [1:0]         res_tag_o,
  output logic [31:0]        res_insn_o,
  output logic [CAUSE_W-1:0] res_cause_o,
  output logic [XLEN-1:0]    res_addr_o
);
  localparam logic [XLEN-1:0]    HALF_STEP = XLEN'(2);
  localparam logic [CAUSE_W-1:0] C_MISAL   = CAUSE_W'(CAUSE_MISALIGN);
  localparam logic [CAUSE_W-1:0] C_ACCESS  = CAUSE_W'(CAUSE_ACCESS);

  seq_state_e state;
  logic misalign, is_half, hi_phase, advance, finish, idle, go, bad_start;

  logic [XLEN-1:0]    vaddr_q, pc_q, res_addr_q;
  logic [PA_W-1:0]    paddr_q;
  logic [15:0]        lo_q;
  logic               res_valid_q;
  res_tag_e           res_tag_q;
  logic [31:0]        res_insn_q;
  logic [CAUSE_W-1:0] res_cause_q;

  ifu_align_chk #(.XLEN(XLEN)) u_align (
    .pc_i      (pc_i),
    .rvc_en_i  (rvc_en_i),
    .misalign_o(misalign)
  );

  ifu_half_classify u_cls (
    .half_i   (mem_rsp_data_i),
    .is_half_o(is_half)
  );

  assign idle      = (state == S_IDLE);
  assign go        = start_i & idle & ~misalign;
  assign bad_start = start_i & idle &  misalign;

  ifu_seq u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .go_i           (go),
    .tr_req_ready_i (tr_req_ready_i),
    .tr_rsp_valid_i (tr_rsp_valid_i),
    .tr_rsp_fault_i (tr_rsp_fault_i),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_err_i  (mem_rsp_err_i),
    .low_is_half_i  (is_half),
    .state_o        (state),
    .hi_phase_o     (hi_phase),
    .advance_o      (advance),
    .finish_o       (finish)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q     <= '0;
      pc_q        <= '0;
      paddr_q     <= '0;
      lo_q        <= '0;
      res_valid_q <= 1'b0;
      res_tag_q   <= RES_FULL;
      res_insn_q  <= '0;
      res_cause_q <= '0;
      res_addr_q  <= '0;
    end else begin
      res_valid_q <= 1'b0;
      if (go) begin
        vaddr_q <= pc_i;
        pc_q    <= pc_i;
      end
      if (bad_start) begin
        res_valid_q <= 1'b1;
        res_tag_q   <= RES_EXC;
        res_cause_q <= C_MISAL;
        res_addr_q  <= pc_i;
      end
      if (state == S_TRSP && tr_rsp_valid_i && !tr_rsp_fault_i) paddr_q <= tr_rsp_paddr_i;
      if (advance) begin
        lo_q    <= mem_rsp_data_i;
        vaddr_q <= vaddr_q + HALF_STEP;
      end
      if (finish) begin
        res_valid_q <= 1'b1;
        if (state == S_TRSP) begin
          // translation fault: exact halfword address
          res_tag_q   <= RES_EXC;
          res_cause_q <= tr_rsp_cause_i;
          res_addr_q  <= vaddr_q;
        end else if (mem_rsp_err_i) begin
          res_tag_q   <= RES_EXC;
          res_cause_q <= C_ACCESS;
          res_addr_q  <= vaddr_q;
        end else if (hi_phase) begin
          res_tag_q   <= RES_FULL;
          res_insn_q  <= {mem_rsp_data_i, lo_q};
          res_addr_q  <= pc_q;
        end else begin
          res_tag_q   <= RES_HALF;
          res_insn_q  <= {16'h0000, mem_rsp_data_i};
          res_addr_q  <= pc_q;
        end
      end
    end
  end

  assign ready_o         = idle;
  assign tr_req_valid_o  = (state == S_TREQ);
  assign tr_vaddr_o      = vaddr_q;
  assign mem_req_valid_o = (state == S_MREQ);
  assign mem_addr_o      = paddr_q;
  assign res_valid_o     = res_valid_q;
  assign res_tag_o       = res_tag_q;
  assign res_insn_o      = res_insn_q;
  assign res_cause_o     = res_cause_q;
  assign res_addr_o      = res_addr_q;
endmodule

// File: rtl/ifu_fetch_chk.sv
module ifu_fetch_chk
  import ifu_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [XLEN-1:0]    pc_i,
  input logic               rvc_en_i,
  input logic               ready_o,
  input logic               tr_req_valid_o,
  input logic               tr_req_ready_i,
  input logic [XLEN-1:0]    tr_vaddr_o,
  input logic               mem_req_valid_o,
  input logic               mem_req_ready_i,
  input logic [PA_W-1:0]    mem_addr_o,
  input logic               res_valid_o,
  input logic [1:0]         res_tag_o,
  input logic [31:0]        res_insn_o,
  input logic [CAUSE_W-1:0] res_cause_o,
  input logic [XLEN-1:0]    res_addr_o
);
  a_r1_misalign_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && ready_o && pc_i[0] |=> res_valid_o && res_tag_o == RES_EXC &&
      res_cause_o == CAUSE_W'(0) && ready_o && !tr_req_valid_o && !mem_req_valid_o);

  a_r2_half_pc_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && ready_o && pc_i[1] && !rvc_en_i |=> res_valid_o && res_tag_o == RES_EXC &&
      res_addr_o == $past(pc_i) && !tr_req_valid_o);

  a_r3_half_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_tag_o == RES_HALF |-> res_insn_o[1:0] != 2'b11 && res_insn_o[31:16] == 16'h0);

  a_r7_full_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_tag_o == RES_FULL |-> res_insn_o[1:0] == 2'b11);

  a_r8_tr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tr_req_valid_o && !tr_req_ready_i |=> tr_req_valid_o && $stable(tr_vaddr_o));

  a_r8_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o));

  a_r9_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !(start_i && ready_o) |=> !res_valid_o);

  a_r9_busy_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tr_req_valid_o || mem_req_valid_o) |-> !ready_o && !(tr_req_valid_o && mem_req_valid_o));
endmodule

bind ifu_fetch_top ifu_fetch_chk #(.XLEN(XLEN), .PA_W(PA_W), .CAUSE_W(CAUSE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .pc_i           (pc_i),
  .rvc_en_i       (rvc_en_i),
  .ready_o        (ready_o),
  .tr_req_valid_o (tr_req_valid_o),
  .tr_req_ready_i (tr_req_ready_i),
  .tr_vaddr_o     (tr_vaddr_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_addr_o     (mem_addr_o),
  .res_valid_o    (res_valid_o),
  .res_tag_o      (res_tag_o),
  .res_insn_o     (res_insn_o),
  .res_cause_o    (res_cause_o),
  .res_addr_o     (res_addr_o)
);

// File: tb/ifu_fetch_top_tb.sv
module ifu_fetch_top_tb;
  localparam logic [31:0] KEY = 32'h5A00_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic        rvc_en_i = 1'b1;
  logic        ready_o;
  logic        tr_req_valid_o, tr_req_ready_i = 1'b0;
  logic [31:0] tr_vaddr_o;
  logic        tr_rsp_valid_i = 1'b0, tr_rsp_fault_i = 1'b0;
  logic [4:0]  tr_rsp_cause_i = '0;
  logic [31:0] tr_rsp_paddr_i = '0;
  logic        mem_req_valid_o, mem_req_ready_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0, mem_rsp_err_i = 1'b0;
  logic [15:0] mem_rsp_data_i = '0;
  logic        res_valid_o;
  logic [1:0]  res_tag_o;
  logic [31:0] res_insn_o;
  logic [4:0]  res_cause_o;
  logic [31:0] res_addr_o;

  int n_chk = 0, n_fail = 0;
  // scenario: mode 0 none, 1 tr fault lo, 2 mem err lo, 3 tr fault hi, 4 mem err hi
  logic [31:0] s_pc;
  logic [15:0] s_lo, s_hi;
  logic [4:0]  s_tc;
  int          s_mode = 0;
  int          tr_n = 0, mem_n = 0;

  always #5 clk_i = ~clk_i;

  ifu_fetch_top u_dut (.*);

  // translation responder
  int     tr_cnt = 0;
  bit     tr_pend = 0;
  logic [31:0] tr_va;
  always @(negedge clk_i) begin
    tr_rsp_valid_i = 1'b0;
    tr_rsp_fault_i = 1'b0;
    if (tr_pend) begin
      if (tr_cnt == 0) begin
        tr_rsp_valid_i = 1'b1;
        tr_rsp_fault_i = (s_mode == 1 && tr_va == s_pc) || (s_mode == 3 && tr_va == s_pc + 32'd2);
        tr_rsp_cause_i = s_tc;
        tr_rsp_paddr_i = tr_va ^ KEY;
        tr_pend = 0;
      end else tr_cnt--;
    end
    tr_req_ready_i = ($urandom % 3) != 0;
    if (!tr_pend && tr_req_valid_o && tr_req_ready_i) begin
      tr_pend = 1; tr_cnt = $urandom % 3; tr_va = tr_vaddr_o; tr_n++;
    end
  end

  // memory responder
  int     m_cnt = 0;
  bit     m_pend = 0;
  logic [31:0] m_pa;
  always @(negedge clk_i) begin
    mem_rsp_valid_i = 1'b0;
    mem_rsp_err_i   = 1'b0;
    if (m_pend) begin
      if (m_cnt == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_err_i   = (s_mode == 2 && m_pa == (s_pc ^ KEY)) ||
                          (s_mode == 4 && m_pa == ((s_pc + 32'd2) ^ KEY));
        mem_rsp_data_i  = (m_pa == (s_pc ^ KEY)) ? s_lo : s_hi;
        m_pend = 0;
      end else m_cnt--;
    end
    mem_req_ready_i = ($urandom % 3) != 0;
    if (!m_pend && mem_req_valid_o && mem_req_ready_i) begin
      m_pend = 1; m_cnt = $urandom % 4; m_pa = mem_addr_o; mem_n++;
    end
  end

  function automatic void expect_of(input logic [31:0] pc, input logic en, input logic [15:0] lo,
      input logic [15:0] hi, input int mode, input logic [4:0] tc,
      output logic [1:0] tag, output logic [31:0] insn, output logic [4:0] cause,
      output logic [31:0] addr, output int ntr, output int nmem, output string req);
    insn = '0; cause = '0; addr = pc;
    if (pc[0] || (pc[1] && !en)) begin
      tag = 2; ntr = 0; nmem = 0; req = pc[0] ? "R1" : "R2";
    end else if (mode == 1) begin
      tag = 2; cause = tc; ntr = 1; nmem = 0; req = "R4";
    end else if (mode == 2) begin
      tag = 2; cause = 5'd1; ntr = 1; nmem = 1; req = "R5";
    end else if (lo[1:0] != 2'b11) begin
      tag = 1; insn = {16'h0, lo}; ntr = 1; nmem = 1; req = "R3";
    end else if (mode == 3) begin
      tag = 2; cause = tc; addr = pc + 32'd2; ntr = 2; nmem = 1; req = "R6";
    end else if (mode == 4) begin
      tag = 2; cause = 5'd1; addr = pc + 32'd2; ntr = 2; nmem = 2; req = "R6";
    end else begin
      tag = 0; insn = {hi, lo}; ntr = 2; nmem = 2; req = "R7";
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_fetch(input logic [31:0] pc, input logic en, input logic [15:0] lo,
                           input logic [15:0] hi, input int mode, input bit poke);
    logic [1:0] etag; logic [31:0] einsn, eaddr; logic [4:0] ecause;
    int entr, enmem, cyc; string req; bit ok;
    while (!ready_o) @(negedge clk_i);
    s_pc = pc; s_lo = lo; s_hi = hi; s_mode = mode; s_tc = 5'($urandom % 32);
    tr_n = 0; mem_n = 0;
    expect_of(pc, en, lo, hi, mode, s_tc, etag, einsn, ecause, eaddr, entr, enmem, req);
    start_i = 1'b1; pc_i = pc; rvc_en_i = en;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      // R9: start while busy must be ignored
      check(!ready_o, "R9", "busy ready_o", 64'(ready_o), 64'd0);
      start_i = 1'b1; pc_i = pc ^ 32'h0000_0101; rvc_en_i = ~en;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!res_valid_o && cyc < 300) begin @(negedge clk_i); cyc++; end
    ok = res_valid_o && res_tag_o == etag && res_addr_o == eaddr &&
         (etag == 2 ? res_cause_o == ecause : res_insn_o == einsn);
    check(ok, req, "result {tag,cause,addr,insn}",
          {res_tag_o, 7'(res_cause_o), res_addr_o[22:0], res_insn_o},
          {etag, 7'(ecause), eaddr[22:0], einsn});
    // R8: access counts (responders vary ready and latency on every handshake)
    check(tr_n == entr && mem_n == enmem, "R8", "access counts {tr,mem}",
          {32'(tr_n), 32'(mem_n)}, {32'(entr), 32'(enmem)});
    @(negedge clk_i);
    check(!res_valid_o && ready_o, "R9", "pulse end {valid,ready}",
          64'({res_valid_o, ready_o}), 64'b01);
    check(tr_n == entr && mem_n == enmem && res_tag_o == etag, "R9", "result held",
          {32'(tr_n), 30'(mem_n), res_tag_o}, {32'(entr), 30'(enmem), etag});
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check(ready_o && !res_valid_o && !tr_req_valid_o && !mem_req_valid_o, "R9", "reset state",
          64'({ready_o, res_valid_o, tr_req_valid_o, mem_req_valid_o}), 64'b1000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // directed
    run_fetch(32'h0000_1001, 1'b1, 16'h1113, 16'h2222, 0, 0);          // R1
    run_fetch(32'h0000_2002, 1'b0, 16'h0001, 16'h2222, 0, 0);          // R2
    run_fetch(32'h0000_2002, 1'b1, 16'h4501, 16'h2222, 0, 0);          // R2 enabled, R3
    run_fetch(32'h0000_3000, 1'b1, 16'hABCE, 16'h2222, 0, 0);          // R3
    run_fetch(32'h0000_4000, 1'b1, 16'h0083, 16'hBEEF, 1, 0);          // R4
    run_fetch(32'h0000_5000, 1'b1, 16'h0083, 16'hBEEF, 2, 0);          // R5
    run_fetch(32'h0000_6002, 1'b1, 16'h0083, 16'hBEEF, 3, 0);          // R6 translation
    run_fetch(32'h0000_7000, 1'b1, 16'h0083, 16'hBEEF, 4, 0);          // R6 memory
    run_fetch(32'h0000_8000, 1'b1, 16'h1297, 16'hCAFE, 0, 0);          // R7
    run_fetch(32'h0000_9000, 1'b1, 16'h0513, 16'h0010, 0, 1);          // R9 busy start
    run_fetch(32'h0000_A000, 1'b1, 16'h1234, 16'h5678, 3, 0);          // R3 wins over hi fault
    // random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] pc;
      logic [15:0] lo;
      pc = $urandom & 32'h00FF_FFFF;
      if (($urandom % 4) != 0) pc[0] = 1'b0;
      lo = 16'($urandom);
      if (($urandom % 3) != 0) lo[1:0] = 2'b11;
      run_fetch(pc, 1'($urandom % 4 != 0), lo, 16'($urandom), int'($urandom % 5),
                1'($urandom % 8 == 0) && pc[0] == 1'b0 && pc[1] == 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule